// File: doc/BRIEF.md
# Deferred Counter Increment Queue

This block holds a small pool of increments that are waiting to be applied to a bank of counters. A requester names a target counter, a signed step and a wait in cycles. The block stamps the entry with an absolute due cycle, which is the internal cycle count plus the wait. The block then keeps the entry until that due cycle is reached.

On every advancing cycle, every pending entry whose due cycle has been reached is added into its counter, and its slot is freed. Entries therefore leave in deadline order rather than arrival order. Any number of entries may mature together. Steps aimed at the same counter are summed before the single write to that counter. The cycle count and all applies advance only while the downstream side reports busy. Counter values are read through an index port, and a full flag reports that no slot is free.

Top module: `dinc_queue`

## Requirements
- R1: After reset `cycle_o` is 0, and it increases by one at each rising clock edge where `busy_i` is 1, wrapping at 16 bits.
- R2: An accepted request with wait D ≥ 1, sampled at the edge where `cycle_o` reads T, has due cycle T+D. Its step is visible on `rd_cnt_o` from the edge that ends the cycle where `cycle_o` reads T+D, provided `busy_i` stays 1.
- R3: A request with wait 0 is applied in the cycle after its insertion, so it shows on `rd_cnt_o` one edge after it is accepted.
- R4: Each accepted entry changes its counter exactly once, and its slot is freed on the same edge as its apply.
- R5: All entries that are due in the same cycle are applied at that edge. Steps aimed at one counter are summed.
- R6: There are 8 slots. `full_o` is 1 exactly when 8 entries are pending. A request presented while `full_o` is 1 is dropped and never applied.
- R7: An insertion and one or more applies on the same edge all take effect.
- R8: `req_delta_i` is an 8-bit two's-complement step, sign-extended to 32 bits. Counters are 32 bits wide and wrap modulo 2^32.
- R9: While `busy_i` is 0, the cycle count and all counters hold and pending entries wait. Requests are still accepted, with due cycle computed from the held count.
- R10: After reset all counters read 0, no entry is pending and `full_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Downstream busy; enables advancing and applying |
| req_valid_i | input | 1 | Request present this cycle |
| req_idx_i | input | 2 | Target counter index |
| req_delta_i | input | 8 | Signed step |
| req_delay_i | input | 8 | Wait in cycles |
| full_o | output | 1 | All slots occupied |
| cycle_o | output | 16 | Internal cycle count |
| rd_idx_i | input | 2 | Counter to read |
| rd_cnt_o | output | 32 | Value of the selected counter |

## Verification
Insertion of a new entry and retirement of matured entries can fall on the same edge, as can two matured entries aimed at one counter. The bench provokes the first case with back-to-back zero-wait requests, so that one entry is stored while its predecessor is added. It provokes the second case by staggering three requests so that their due cycles coincide, two of them on the same counter. A reference model built from the requirements tracks pending entries, the cycle count and every counter. The model is compared with all counters, the full flag and the cycle count on every cycle, so a lost insert, a missed or doubled apply, or an unsummed collision shows as a value mismatch.

// File: rtl/dinc_pkg.sv
package dinc_pkg;
    localparam int DEF_DEPTH = 8;   // pending slots
    localparam int DEF_NCNT  = 4;   // counters in the bank
    localparam int DEF_DW    = 8;   // step width
    localparam int DEF_CW    = 32;  // counter width
    localparam int DEF_LW    = 8;   // wait width
    localparam int DEF_TW    = 16;  // cycle count width
endpackage

// File: rtl/dinc_slot_pick.sv
module dinc_slot_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] free_i,
    output logic [N-1:0] gnt_o
);
    always_comb begin
        logic found;
        found = 1'b0;
        gnt_o = '0;
        for (int k = 0; k < N; k++) begin
            if (free_i[k] && !found) begin
                gnt_o[k] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dinc_due_scan.sv
module dinc_due_scan #(
    parameter int N  = 8,
    parameter int TW = 16
) (
    input  logic [TW-1:0]   now_i,
    input  logic [N-1:0]    vld_i,
    input  logic [N*TW-1:0] due_i,
    output logic [N-1:0]    ripe_o
);
    for (genvar k = 0; k < N; k++) begin : g_cmp
        logic [TW-1:0] gap;
        // wrap-safe "due <= now": the difference is non-negative
        assign gap       = now_i - due_i[k*TW +: TW];
        assign ripe_o[k] = vld_i[k] & ~gap[TW-1];
    end
endmodule

// File: rtl/dinc_delta_sum.sv
module dinc_delta_sum #(
    parameter int N    = 8,
    parameter int NCNT = 4,
    parameter int IW   = 2,
    parameter int DW   = 8,
    parameter int CW   = 32
) (
    input  logic [N-1:0]       sel_i,
    input  logic [N*IW-1:0]    idx_i,
    input  logic [N*DW-1:0]    dlt_i,
    output logic [NCNT*CW-1:0] sum_o
);
    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
        always_comb begin
            logic [CW-1:0] acc;
            logic [DW-1:0] d;
            acc = '0;
            for (int e = 0; e < N; e++) begin
                d = dlt_i[e*DW +: DW];
                if (sel_i[e] && idx_i[e*IW +: IW] == IW'(c))
                    acc = acc + {{(CW-DW){d[DW-1]}}, d};
            end
            sum_o[c*CW +: CW] = acc;
        end
    end
endmodule

// File: rtl/dinc_queue.sv
module dinc_queue
    import dinc_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int NCNT  = DEF_NCNT,
    parameter int DW    = DEF_DW,
    parameter int CW    = DEF_CW,
    parameter int LW    = DEF_LW,
    parameter int TW    = DEF_TW,
    localparam int IW   = $clog2(NCNT)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          busy_i,
    input  logic          req_valid_i,
    input  logic [IW-1:0] req_idx_i,
    input  logic [DW-1:0] req_delta_i,
    input  logic [LW-1:0] req_delay_i,
    output logic          full_o,
    output logic [TW-1:0] cycle_o,
    input  logic [IW-1:0] rd_idx_i,
    output logic [CW-1:0] rd_cnt_o
);
    typedef struct packed {
        logic [DEPTH-1:0]           vld;
        logic [DEPTH-1:0][IW-1:0]   idx;
        logic [DEPTH-1:0][DW-1:0]   dlt;
        logic [DEPTH-1:0][TW-1:0]   due;
        logic [NCNT-1:0][CW-1:0]    cnt;
        logic [TW-1:0]              now;
    } state_t;

    state_t st_d, st_q;

    logic [DEPTH-1:0]       ripe;
    logic [DEPTH-1:0]       apply_mask;
    logic [DEPTH-1:0]       gnt;
    logic [NCNT*CW-1:0]     sums;
    logic                   accept;

    dinc_due_scan #(.N(DEPTH), .TW(TW)) u_scan (
        .now_i  (st_q.now),
        .vld_i  (st_q.vld),
        .due_i  (st_q.due),
        .ripe_o (ripe)
    );

    assign apply_mask = busy_i ? ripe : '0;

    dinc_delta_sum #(.N(DEPTH), .NCNT(NCNT), .IW(IW), .DW(DW), .CW(CW)) u_sum (
        .sel_i (apply_mask),
        .idx_i (st_q.idx),
        .dlt_i (st_q.dlt),
        .sum_o (sums)
    );

    dinc_slot_pick #(.N(DEPTH)) u_pick (
        .free_i (~st_q.vld),
        .gnt_o  (gnt)
    );

    assign full_o  = &st_q.vld;
    assign accept  = req_valid_i && !full_o;
    assign cycle_o = st_q.now;

    always_comb begin
        st_d = st_q;
        // retire matured entries and fold their steps into the bank
        st_d.vld = st_q.vld & ~apply_mask;
        if (busy_i) begin
            st_d.now = st_q.now + TW'(1);
            for (int c = 0; c < NCNT; c++)
                st_d.cnt[c] = st_q.cnt[c] + sums[c*CW +: CW];
        end
        // store a new entry in the lowest free slot
        if (accept) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (gnt[k]) begin
                    st_d.vld[k] = 1'b1;
                    st_d.idx[k] = req_idx_i;
                    st_d.dlt[k] = req_delta_i;
                    st_d.due[k] = st_q.now + TW'(req_delay_i);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rd_cnt_o = (32'(rd_idx_i) < NCNT) ? st_q.cnt[rd_idx_i] : '0;
endmodule

// File: rtl/dinc_queue_chk.sv
module dinc_queue_chk #(
    parameter int DEPTH = 8,
    parameter int NCNT  = 4,
    parameter int CW    = 32,
    parameter int TW    = 16
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 busy_i,
    input logic                 req_valid_i,
    input logic                 full_o,
    input logic [TW-1:0]        cycle_o,
    input logic [DEPTH-1:0]     vld_i,
    input logic [DEPTH-1:0]     apply_i,
    input logic [NCNT*CW-1:0]   cnt_i
);
    a_r1_cycle_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |=> cycle_o == $past(cycle_o) + TW'(1));

    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_i |=> ($stable(cycle_o) && $stable(cnt_i)));

    a_r4_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (apply_i != '0) |=> ((vld_i & $past(apply_i)) == '0));

    a_r6_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && req_valid_i && !busy_i) |=> full_o);

    a_r7_occupancy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !full_o) |=>
        $countones(vld_i) == $past($countones(vld_i)) - $past($countones(apply_i)) + 1);
endmodule

bind dinc_queue dinc_queue_chk #(.DEPTH(DEPTH), .NCNT(NCNT), .CW(CW), .TW(TW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_i),
    .req_valid_i (req_valid_i),
    .full_o      (full_o),
    .cycle_o     (cycle_o),
    .vld_i       (st_q.vld),
    .apply_i     (apply_mask),
    .cnt_i       (st_q.cnt)
);

// File: tb/dinc_queue_bench.sv
module dinc_queue_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int NCNT  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_idx = '0;
    logic [7:0]  req_delta = '0;
    logic [7:0]  req_delay = '0;
    logic        full;
    logic [15:0] cyc;
    logic [1:0]  rd_idx = '0;
    logic [31:0] rd_cnt;

    dinc_queue u_dinc_queue (
        .clk_i(clk), .rst_ni(rst_n), .busy_i(busy),
        .req_valid_i(req_valid), .req_idx_i(req_idx),
        .req_delta_i(req_delta), .req_delay_i(req_delay),
        .full_o(full), .cycle_o(cyc), .rd_idx_i(rd_idx), .rd_cnt_o(rd_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { int idx; int delta; int due; } pend_t;
    pend_t       pend[$];
    logic [31:0] mcnt [NCNT];
    int          mnow;
    string       cur_req = "R10";
    int          n_chk = 0;
    int          n_fail = 0;
    bit          mon_en = 0;

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // reference model: advances at every edge from the requirements
    always @(posedge clk) begin
        bit acc;
        if (!rst_n) begin
            pend.delete();
            for (int i = 0; i < NCNT; i++) mcnt[i] = '0;
            mnow = 0;
        end else begin
            acc = req_valid && (pend.size() < DEPTH);
            if (busy) begin
                for (int k = pend.size() - 1; k >= 0; k--) begin
                    if (pend[k].due <= mnow) begin
                        mcnt[pend[k].idx] = mcnt[pend[k].idx] + 32'(pend[k].delta);
                        pend.delete(k);
                    end
                end
            end
            if (acc)
                pend.push_back('{int'(req_idx), int'($signed(req_delta)), mnow + int'(req_delay)});
            if (busy) mnow++;
        end
    end

    // monitor: compare every counter, the full flag and the cycle count
    always @(negedge clk) begin
        if (mon_en) begin
            for (int i = 0; i < NCNT; i++) begin
                rd_idx = 2'(i);
                #1;
                chk(rd_cnt == mcnt[i], cur_req, rd_cnt, mcnt[i]);
            end
            chk(full == (pend.size() == DEPTH), "R6 full flag", full, pend.size() == DEPTH);
            chk(cyc == 16'(mnow), busy ? "R1 cycle" : "R9 cycle", cyc, 16'(mnow));
        end
    end

    task automatic ins(int idx, int delta, int delay);
        @(negedge clk);
        req_valid = 1'b1;
        req_idx   = 2'(idx);
        req_delta = 8'(delta);
        req_delay = 8'(delay);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        mon_en = 1'b1;
        cur_req = "R10 reset";
        idle(2);

        cur_req = "R2 timed apply";
        ins(0, 5, 3);
        idle(6);

        cur_req = "R3 zero wait";
        ins(1, -3, 0);
        idle(3);

        cur_req = "R8 sign and wrap";
        ins(2, -128, 2);
        idle(1);
        ins(2, 127, 0);
        ins(2, 1, 1);
        ins(3, -1, 0);
        idle(4);

        cur_req = "R5 same-cycle collision";
        ins(3, 10, 4);
        ins(3, 20, 3);
        ins(1, 7, 2);
        idle(6);

        cur_req = "R6 capacity";
        for (int k = 0; k < 10; k++) ins(k % 4, 1, 40);
        idle(3);
        ins(0, 100, 0);
        idle(46);

        cur_req = "R7 insert with apply";
        for (int k = 0; k < 10; k++) ins(k % 4, k - 5, 0);
        ins(1, 50, 5);
        ins(1, -20, 0);
        idle(8);

        cur_req = "R9 busy low";
        @(negedge clk);
        busy = 1'b0;
        ins(0, 9, 0);
        ins(3, 4, 2);
        idle(5);
        busy = 1'b1;
        idle(6);

        cur_req = "R4 applied once";
        idle(5);

        mon_en = 1'b0;
        summary();
        $finish;
    end
endmodule